// File: doc/BRIEF.md
# Platform-level interrupt controller core

This block collects a parameterised set of external interrupt sources and routes them to a small number of target contexts. Each context usually stands for one privilege level of one hart. Every source passes through its own gateway, which turns a level-high or rising-edge input into a single pending request. The gateway then holds that source off until software reports that the interrupt has been handled. Every source carries a small priority value. Every context has an enable bit for each source and a priority threshold. For each context the block drives one interrupt line, which is high while some source is pending, enabled for that context and above its threshold.

Software runs a two-step handshake through a per-context claim/complete register. Reading it returns the best eligible source, that is the highest priority with ties going to the lowest ID. The read also removes that source from pending. Writing the same ID back afterwards re-arms the source's gateway. ID 0 is reserved: it never exists as a source, and a claim value of 0 means nothing is waiting.

The register port is a single-cycle bus with no back-pressure. Every access with `bus_sel` high completes in the cycle it is presented, and there is no ready signal. Read data appears on `bus_rdata` on the clock edge that takes the read and stays there until the next read. Writes take effect on that same edge.

Top module: `irq_router`

## Requirements
- R1: After reset every priority, enable, threshold and trigger-mode register reads 0, no source is pending, every `irq_o` bit is low, and a claim read returns 0.
- R2: The priority of source ID sits at byte address 4*ID and holds 3 bits; the upper bits read as 0. The register for ID 0 reads 0 and ignores writes. Read data appears on `bus_rdata` in the cycle after the read is presented.
- R3: Reads of any address outside the map return 0. Writes there change no register. Bits [1:0] of the address are ignored.
- R4: A pending, enabled source is eligible for a context only when its priority is strictly greater than that context's 3-bit threshold. The threshold sits at 0x200000 + ctx*0x1000. A priority of 0 never interrupts, and a threshold of 7 blocks every source.
- R5: Among the eligible sources of a context, the winner is the one with the highest priority. Ties go to the lowest ID.
- R6: A read of the claim/complete register at 0x200004 + ctx*0x1000 returns the current winner of that context and clears its pending bit. The read returns 0 and changes nothing when no source is eligible.
- R7: Once a source has been latched as pending, its gateway takes no new request from it until a completion for it is honoured.
- R8: A completion is a write of the source ID to a context's claim/complete register. It is honoured only if that source is enabled for that context at the time of the write. Otherwise the gateway stays blocked.
- R9: In level mode, a source whose input is still high when its completion is honoured becomes pending again. A source whose input is low stays idle.
- R10: The trigger mode of source ID is bit ID mod 32 of the word at 0x1080 + 4*(ID/32), where 1 selects rising edge and 0 selects level high. In edge mode one rising edge is latched as a request. One further rising edge seen while the source is blocked is remembered, and becomes a new pending request when the completion is honoured.
- R11: `irq_o` is registered. It rises on the second rising clock edge after a source input rises (one edge in the gateway, one in the output register). It falls on the edge after the claim read that empties the context.
- R12: The enable bitmap of a context starts at 0x2000 + ctx*0x80. Source ID is bit ID mod 32 of word ID/32. The pending bits read at 0x1000 with the same packing. Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt source inputs, bit n is source ID n; bit 0 is unused |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
Threshold handling is checked by holding a single source steady while its context's threshold moves through equal, lower and maximum values. This separates a strict comparison from a greater-or-equal one. Priority ordering is tried with two sources of equal priority next to a lower one, and with random priority, enable and threshold sets on two contexts. Each random set is drained by repeated claims, which shows whether the ordering, the tie rule and the split of sources between contexts are right. The gateway is tried with level inputs held across a completion, with a completion sent while the source is disabled, and with edge pulses sent both before and during the blocked window. These cases tell the re-arm, blocking and remembered-edge behaviours apart.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] MODE_BASE  = 32'h0000_1080;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_MODE,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] idx;
    logic [7:0]  ctx;
  } reg_hit_t;

endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned ADDR_W  = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);

  localparam int unsigned NW       = (NUM_SRC + 31) / 32;
  localparam logic [31:0] PRIO_END = 32'(4 * NUM_SRC);
  localparam logic [31:0] PEND_END = PEND_BASE + 32'(4 * NW);
  localparam logic [31:0] MODE_END = MODE_BASE + 32'(4 * NW);
  localparam logic [31:0] EN_END   = EN_BASE + EN_STRIDE * 32'(NUM_CTX);
  localparam logic [31:0] CTX_END  = CTX_BASE + CTX_STRIDE * 32'(NUM_CTX);
  localparam logic [31:0] EN_WORDS = 32'(4 * NW);

  logic [31:0] a;
  logic [31:0] off;

  always_comb begin
    a   = 32'(addr) & ~32'h3;
    off = '0;
    hit = '0;
    hit.kind = RG_NONE;
    if (a < PRIO_END) begin
      hit.kind = RG_PRIO;
      hit.idx  = a[17:2];
    end else if (a >= PEND_BASE && a < PEND_END) begin
      off      = a - PEND_BASE;
      hit.kind = RG_PEND;
      hit.idx  = off[17:2];
    end else if (a >= MODE_BASE && a < MODE_END) begin
      off      = a - MODE_BASE;
      hit.kind = RG_MODE;
      hit.idx  = off[17:2];
    end else if (a >= EN_BASE && a < EN_END) begin
      off = a - EN_BASE;
      if (32'(off[6:0]) < EN_WORDS) begin
        hit.kind = RG_EN;
        hit.ctx  = off[14:7];
        hit.idx  = {11'b0, off[6:2]};
      end
    end else if (a >= CTX_BASE && a < CTX_END) begin
      off     = a - CTX_BASE;
      hit.ctx = off[19:12];
      if (off[11:0] == 12'h000) hit.kind = RG_THR;
      else if (off[11:0] == 12'h004) hit.kind = RG_CLAIM;
    end
  end

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic edge_mode,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic busy
);

  logic prev_q;
  logic pend_q;
  logic busy_q;
  logic held_q;
  logic rise;
  logic req;

  assign rise = src & ~prev_q;
  assign req  = edge_mode ? rise : src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= src;
      if (!busy_q) begin
        if (req) begin
          pend_q <= 1'b1;
          busy_q <= 1'b1;
        end
      end else if (complete && !pend_q) begin
        if (held_q) begin
          pend_q <= 1'b1;
          held_q <= 1'b0;
        end else begin
          busy_q <= 1'b0;
        end
      end else begin
        if (claim) pend_q <= 1'b0;
        if (edge_mode && rise) held_q <= 1'b1;
      end
    end
  end

  assign pending = pend_q;
  assign busy    = busy_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned IDW    = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              pend,
  input  logic [NUM_SRC-1:0]              en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input  logic [PRIO_W-1:0]               thr,
  output logic [IDW-1:0]                  win_id,
  output logic                            win_valid,
  output logic                            irq
);

  logic [PRIO_W-1:0] best_p;
  logic [IDW-1:0]    best_id;
  logic              irq_q;

  // Scan upward; a later source must beat the current best strictly,
  // so equal priorities keep the lower ID. Starting at the threshold
  // makes the strict threshold compare fall out of the same chain.
  always_comb begin
    best_p  = thr;
    best_id = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (pend[i] && en[i] && (prio[i] > best_p)) begin
        best_p  = prio[i];
        best_id = IDW'(i);
      end
    end
  end

  assign win_id    = best_id;
  assign win_valid = (best_id != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= win_valid;
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CTX-1:0] irq_o
);

  localparam int unsigned NW   = (NUM_SRC + 31) / 32;
  localparam int unsigned PADN = NW * 32;
  localparam int unsigned IDW  = $clog2(NUM_SRC);

  reg_hit_t                              hit;
  logic                                  rd;
  logic                                  wr;
  logic [NUM_SRC-1:0][PRIO_W-1:0]        prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0]       en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]        thr_q;
  logic [NUM_SRC-1:0]                    mode_q;
  logic [NUM_SRC-1:0]                    pending;
  logic [NUM_SRC-1:0]                    busy;
  logic [NUM_SRC-1:0]                    claim_v;
  logic [NUM_SRC-1:0]                    done_v;
  logic [NUM_CTX-1:0][IDW-1:0]           win_id;
  logic [NUM_CTX-1:0]                    win_valid;
  logic [PADN-1:0]                       pend_pad;
  logic [PADN-1:0]                       mode_pad;
  logic [NUM_CTX-1:0][PADN-1:0]          en_pad;
  logic [31:0]                           rd_val;
  logic [31:0]                           rdata_q;

  assign rd = bus_sel & ~bus_we;
  assign wr = bus_sel &  bus_we;

  irq_decode #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .addr(bus_addr),
    .hit (hit)
  );

  // Per-source gateways; ID 0 has none.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == 0) begin : g_none
      assign pending[i] = 1'b0;
      assign busy[i]    = 1'b0;
    end else begin : g_gw
      irq_gateway u_gw (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_i[i]),
        .edge_mode(mode_q[i]),
        .claim    (claim_v[i]),
        .complete (done_v[i]),
        .pending  (pending[i]),
        .busy     (busy[i])
      );
    end
  end

  // One arbiter per context.
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_arbiter #(
      .NUM_SRC(NUM_SRC),
      .PRIO_W (PRIO_W)
    ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pending),
      .en       (en_q[c]),
      .prio     (prio_q),
      .thr      (thr_q[c]),
      .win_id   (win_id[c]),
      .win_valid(win_valid[c]),
      .irq      (irq_o[c])
    );
    assign en_pad[c] = PADN'(en_q[c]);
  end

  assign pend_pad = PADN'(pending);
  assign mode_pad = PADN'(mode_q);

  // Claim on read of a non-empty context; completion on a write of an
  // enabled, existing ID.
  always_comb begin
    claim_v = '0;
    done_v  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (hit.kind == RG_CLAIM && hit.ctx == 8'(c)) begin
        if (rd && win_valid[c]) claim_v[win_id[c]] = 1'b1;
        if (wr) begin
          for (int i = 1; i < NUM_SRC; i++) begin
            if (bus_wdata == 32'(i) && en_q[c][i]) done_v[i] = 1'b1;
          end
        end
      end
    end
  end

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
      mode_q <= '0;
    end else if (wr) begin
      case (hit.kind)
        RG_PRIO: begin
          for (int i = 1; i < NUM_SRC; i++) begin
            if (hit.idx == 16'(i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
          end
        end
        RG_MODE: begin
          for (int i = 1; i < NUM_SRC; i++) begin
            if (hit.idx == 16'(i / 32)) mode_q[i] <= bus_wdata[i % 32];
          end
        end
        RG_EN: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            for (int i = 1; i < NUM_SRC; i++) begin
              if (hit.ctx == 8'(c) && hit.idx == 16'(i / 32))
                en_q[c][i] <= bus_wdata[i % 32];
            end
          end
        end
        RG_THR: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            if (hit.ctx == 8'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  // Read multiplexer.
  always_comb begin
    rd_val = '0;
    case (hit.kind)
      RG_PRIO: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (hit.idx == 16'(i)) rd_val = 32'(prio_q[i]);
        end
      end
      RG_PEND: begin
        for (int w = 0; w < NW; w++) begin
          if (hit.idx == 16'(w)) rd_val = pend_pad[w*32 +: 32];
        end
      end
      RG_MODE: begin
        for (int w = 0; w < NW; w++) begin
          if (hit.idx == 16'(w)) rd_val = mode_pad[w*32 +: 32];
        end
      end
      RG_EN: begin
        for (int c = 0; c < NUM_CTX; c++) begin
          for (int w = 0; w < NW; w++) begin
            if (hit.ctx == 8'(c) && hit.idx == 16'(w))
              rd_val = en_pad[c][w*32 +: 32];
          end
        end
      end
      RG_THR: begin
        for (int c = 0; c < NUM_CTX; c++) begin
          if (hit.ctx == 8'(c)) rd_val = 32'(thr_q[c]);
        end
      end
      RG_CLAIM: begin
        for (int c = 0; c < NUM_CTX; c++) begin
          if (hit.ctx == 8'(c)) rd_val = 32'(win_id[c]);
        end
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned IDW    = $clog2(NUM_SRC)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_sel,
  input logic                            bus_we,
  input logic [31:0]                     bus_rdata,
  input logic [NUM_CTX-1:0]              irq_o,
  input reg_kind_e                       kind,
  input logic [7:0]                      ctx,
  input logic [NUM_SRC-1:0]              pending,
  input logic [NUM_SRC-1:0]              busy,
  input logic [NUM_SRC-1:0]              done_v,
  input logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q,
  input logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q,
  input logic [NUM_CTX-1:0][IDW-1:0]     win_id,
  input logic [NUM_CTX-1:0]              win_valid
);

  // R3: unmapped reads return zero
  a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && kind == RG_NONE) |=> (bus_rdata == 32'd0));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
    // R4: a winner always lies strictly above the threshold
    a_r4_winner_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid[c] |-> (prio_q[win_id[c]] > thr_q[c]));

    // R11: the line is high only if some enabled source was pending
    a_r11_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> $past(|(pending & en_q[c])));

    // R6: a claim read clears the pending bit of the returned source
    a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && kind == RG_CLAIM && ctx == 8'(c) && win_valid[c])
      |=> !pending[$past(win_id[c])]);
  end

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src_chk
    // R7: a blocked source does not become pending without completion
    a_r7_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[i] && !pending[i] && !done_v[i]) |=> !pending[i]);
  end

endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_CTX(NUM_CTX),
  .PRIO_W (PRIO_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .kind     (hit.kind),
  .ctx      (hit.ctx),
  .pending  (pending),
  .busy     (busy),
  .done_v   (done_v),
  .en_q     (en_q),
  .prio_q   (prio_q),
  .thr_q    (thr_q),
  .win_id   (win_id),
  .win_valid(win_valid)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;

  localparam int N = 32;
  localparam int C = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src;
  logic        sel;
  logic        we;
  logic [23:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [C-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          mprio [N];
  logic [31:0] men   [C];
  int          mthr  [C];
  int          owner [N];

  always #10 clk = ~clk;

  irq_router u_irq_router (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src),
    .bus_sel  (sel),
    .bus_we   (we),
    .bus_addr (addr),
    .bus_wdata(wdata),
    .bus_rdata(rdata),
    .irq_o    (irq)
  );

  function automatic logic [31:0] a_prio(int id);  return 32'(4 * id); endfunction
  function automatic logic [31:0] a_en(int c);     return 32'h2000 + 32'(c * 128); endfunction
  function automatic logic [31:0] a_thr(int c);    return 32'h20_0000 + 32'(c * 4096); endfunction
  function automatic logic [31:0] a_claim(int c);  return 32'h20_0004 + 32'(c * 4096); endfunction
  localparam logic [31:0] A_PEND = 32'h1000;
  localparam logic [31:0] A_MODE = 32'h1080;

  function automatic int best(logic [31:0] m, int c);
    int bp = mthr[c];
    int bi = 0;
    for (int i = 1; i < N; i++) begin
      if (m[i] && men[c][i] && mprio[i] > bp) begin
        bp = mprio[i];
        bi = i;
      end
    end
    return bi;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a[23:0]; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a[23:0];
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    int          ex;
    int          seed;
    seed = $urandom(32'h1d2c);
    src = '0; sel = 0; we = 0; addr = '0; wdata = '0; rst_n = 0;
    waitn(3);
    rst_n = 1;
    waitn(1);

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd(a_claim(0), d); chk("R1 claim after reset", d, 0);
    rd(a_prio(5), d);  chk("R1 prio after reset", d, 0);
    rd(a_en(1), d);    chk("R1 enable after reset", d, 0);
    rd(a_thr(1), d);   chk("R1 threshold after reset", d, 0);
    rd(A_MODE, d);     chk("R1 mode after reset", d, 0);

    // R2 priority width and ID 0
    wr(a_prio(3), 32'hFFFF_FFFF); rd(a_prio(3), d); chk("R2 prio 3 bits", d, 7);
    wr(a_prio(0), 32'hFFFF_FFFF); rd(a_prio(0), d); chk("R2 prio id0", d, 0);
    wr(a_prio(3), 0);

    // R3 unmapped space
    wr(32'h80, 32'hFFFF_FFFF);
    wr(32'h2100, 32'hFFFF_FFFF);
    wr(32'h20_0008, 32'hFFFF_FFFF);
    wr(32'h20_2000, 32'hFFFF_FFFF);
    rd(32'h80, d);      chk("R3 unmapped prio", d, 0);
    rd(32'h2100, d);    chk("R3 unmapped enable", d, 0);
    rd(32'h20_0008, d); chk("R3 unmapped ctx offset", d, 0);
    rd(32'h3000, d);    chk("R3 unmapped hole", d, 0);
    rd(a_en(0), d);     chk("R3 enable untouched", d, 0);
    rd(a_thr(0), d);    chk("R3 threshold untouched", d, 0);

    // R12 enable packing, bit 0
    wr(a_en(0), 32'hFFFF_0001); rd(a_en(0), d); chk("R12 enable bits", d, 32'hFFFF_0000);
    wr(a_en(0) + 2, 32'h0000_0021); rd(a_en(0), d); chk("R3 low address bits ignored", d, 32'h20);

    // R4 threshold strictness
    wr(a_prio(5), 3); wr(a_thr(0), 3);
    @(negedge clk); src[5] = 1'b1;
    waitn(4);
    chk("R4 equal to threshold blocks", 32'(irq[0]), 0);
    rd(A_PEND, d); chk("R12 pending packing", d, 32'h20);
    wr(a_thr(0), 2); waitn(1); chk("R4 above threshold", 32'(irq[0]), 1);
    wr(a_thr(0), 7); waitn(1); chk("R4 threshold 7 blocks", 32'(irq[0]), 0);
    wr(a_thr(0), 0); wr(a_prio(5), 0); waitn(1);
    chk("R4 prio 0 masks", 32'(irq[0]), 0);
    rd(a_claim(0), d); chk("R6 claim empty", d, 0);

    // R6 / R11 claim and deassert
    wr(a_prio(5), 3); waitn(1);
    rd(a_claim(0), d); chk("R6 claim returns id", d, 5);
    chk("R11 irq high through claim", 32'(irq[0]), 1);
    waitn(1); chk("R11 irq drops after claim", 32'(irq[0]), 0);
    rd(A_PEND, d); chk("R6 pending cleared", d, 0);
    src[5] = 1'b0;
    wr(a_claim(0), 5); waitn(2);

    // R11 rise latency
    wr(a_en(0), 32'h80); wr(a_prio(7), 1);
    @(negedge clk); src[7] = 1'b1;
    @(negedge clk); chk("R11 low one edge after source", 32'(irq[0]), 0);
    @(negedge clk); chk("R11 high two edges after source", 32'(irq[0]), 1);
    rd(a_claim(0), d); chk("R6 claim 7", d, 7);
    src[7] = 1'b0; wr(a_claim(0), 7); wr(a_prio(7), 0);

    // R5 tie to lowest id
    wr(a_en(0), 32'h1210); wr(a_prio(4), 5); wr(a_prio(9), 5); wr(a_prio(12), 2);
    @(negedge clk); src[4] = 1; src[9] = 1; src[12] = 1;
    waitn(3);
    rd(a_claim(0), d); chk("R5 tie lowest id", d, 4);
    rd(a_claim(0), d); chk("R5 tie second", d, 9);
    rd(a_claim(0), d); chk("R5 lower prio last", d, 12);
    rd(a_claim(0), d); chk("R6 empty after drain", d, 0);
    src[4] = 0; src[9] = 0; src[12] = 0;
    wr(a_claim(0), 4); wr(a_claim(0), 9); wr(a_claim(0), 12);
    wr(a_prio(4), 0); wr(a_prio(9), 0); wr(a_prio(12), 0);
    waitn(2);
    rd(A_PEND, d); chk("R9 low inputs stay idle", d, 0);

    // R7 / R8 / R9 level gateway
    wr(a_en(0), 32'h40); wr(a_prio(6), 2);
    @(negedge clk); src[6] = 1'b1;
    waitn(3);
    rd(a_claim(0), d); chk("R6 claim 6", d, 6);
    wr(a_en(0), 0); wr(a_claim(0), 6); wr(a_en(0), 32'h40);
    waitn(3);
    rd(A_PEND, d); chk("R8 completion while disabled ignored", d, 0);
    rd(a_claim(0), d); chk("R7 blocked source not claimable", d, 0);
    wr(a_claim(0), 6); waitn(3);
    rd(A_PEND, d); chk("R9 level high re-pends", d, 32'h40);
    src[6] = 1'b0;
    rd(a_claim(0), d); chk("R6 claim 6 again", d, 6);
    wr(a_claim(0), 6); waitn(3);
    rd(A_PEND, d); chk("R9 level low stays idle", d, 0);
    wr(a_prio(6), 0);

    // R10 edge gateway
    wr(A_MODE, 32'h400); rd(A_MODE, d); chk("R10 mode readback", d, 32'h400);
    wr(a_en(0), 32'h400); wr(a_prio(10), 4);
    @(negedge clk); src[10] = 1'b1; @(negedge clk); src[10] = 1'b0;
    waitn(2);
    rd(A_PEND, d); chk("R10 edge latched", d, 32'h400);
    rd(a_claim(0), d); chk("R10 claim edge source", d, 10);
    @(negedge clk); src[10] = 1'b1; @(negedge clk); src[10] = 1'b0;
    waitn(2);
    rd(A_PEND, d); chk("R7 edge while blocked not pending", d, 0);
    wr(a_claim(0), 10); waitn(2);
    rd(A_PEND, d); chk("R10 remembered edge re-pends", d, 32'h400);
    rd(a_claim(0), d); chk("R10 claim remembered edge", d, 10);
    wr(a_claim(0), 10); waitn(3);
    rd(A_PEND, d); chk("R10 no extra request", d, 0);
    wr(A_MODE, 0); wr(a_prio(10), 0);

    // Random priority / enable / threshold sets on both contexts
    for (int it = 0; it < 6; it++) begin
      for (int i = 1; i < N; i++) begin
        mprio[i] = $urandom_range(0, 7);
        wr(a_prio(i), 32'(mprio[i]));
      end
      for (int c = 0; c < C; c++) begin
        men[c] = $urandom & 32'hFFFF_FFFE;
        mthr[c] = $urandom_range(0, 3);
        wr(a_en(c), men[c]);
        wr(a_thr(c), 32'(mthr[c]));
      end
      @(negedge clk); src = 32'hFFFF_FFFE;
      waitn(3);
      m = 32'hFFFF_FFFE;
      for (int i = 0; i < N; i++) owner[i] = -1;
      for (int c = 0; c < C; c++) begin
        for (int k = 0; k < N + 1; k++) begin
          ex = best(m, c);
          rd(a_claim(c), d);
          chk("R5 random claim order", d, 32'(ex));
          chk("R11 random irq level", 32'(irq[c]), 32'(ex != 0));
          if (ex == 0) break;
          m[ex] = 1'b0;
          owner[ex] = c;
        end
      end
      src = '0;
      for (int i = 1; i < N; i++) begin
        if (owner[i] >= 0) wr(a_claim(owner[i]), 32'(i));
      end
      for (int i = 1; i < N; i++) begin
        mprio[i] = 7;
        wr(a_prio(i), 7);
      end
      men[0] = 32'hFFFF_FFFE; wr(a_en(0), men[0]);
      mthr[0] = 0; wr(a_thr(0), 0);
      for (int k = 0; k < N + 1; k++) begin
        ex = best(m, 0);
        rd(a_claim(0), d);
        chk("R6 drain claim", d, 32'(ex));
        if (ex == 0) break;
        m[ex] = 1'b0;
        wr(a_claim(0), 32'(ex));
      end
      waitn(2);
      rd(A_PEND, d); chk("R7 all drained", d, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule